// File: doc/BRIEF.md
# Power Management Event Register Window

This block holds the event side of a power management controller. It has a status register, an enable register and a control register. All three are 16 bits wide. It also has a free-running power management timer. Software reaches these registers through a small I/O window. A configuration register sets the base address of the window, and a configuration enable bit turns decoding on or off.

Four event sources set status bits: the timer overflow, a global lock event, a power button event and a real-time clock event. A level system control interrupt (SCI) is high while any of these four status bits is set together with its matching enable bit. Software clears a status bit by writing a 1 to it. The timer counts one step on each cycle that the tick input is high. Its status bit is set each time the counter's top bit changes value, in either direction.

Top module: `pm_evt_block`

## Requirements
- R1: After reset, status, enable, control and the timer are all zero, `ctl_o` is zero and `sci_o` is low.
- R2: An access hits the window only when `cfg_dec_en_i` is 1 and `io_addr_i[15:6]` equals `cfg_base_i[15:6]`. On a miss, `io_hit_o` is 0, reads return 0 and writes change nothing.
- R3: Only `io_addr_i[3:0]` selects the register inside the 64-byte window. For 16-bit accesses, offset 0x0 is status, 0x2 is enable and 0x4 is control. Offset 0x12, for example, aliases 0x2.
- R4: Enable and control are 16-bit read/write registers. A read returns the last value written. `ctl_o` always shows the control register.
- R5: The implemented status bits are timer at bit 0, global lock at bit 5, power button at bit 8 and RTC at bit 10. Writing 1 to a status bit clears it, writing 0 leaves it unchanged, and all other status bits read as 0.
- R6: A one-cycle pulse on `gbl_evt_i`, `pwrbtn_evt_i` or `rtc_evt_i` sets its status bit on the next edge. When a pulse and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R7: `sci_o` equals the OR of status AND enable over bits 0, 5, 8 and 10. Enable bits outside those four never raise it. It follows any status or enable change one cycle after the write or event.
- R8: The timer adds 1, wrapping, on each edge where `tmr_tick_i` is 1. A 32-bit read at offset 0x8 returns the count with zeros above it.
- R9: The timer status bit (bit 0) is set on the edge where the timer's most significant bit changes, either from 0 to 1 or from 1 to 0. That bit is bit 23 at the default width.
- R10: 32-bit writes are ignored. A 32-bit read at any offset other than 0x8, and a 16-bit read at 0x8 or at an unassigned offset, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 16 | Window base address from configuration; bits [5:0] are ignored |
| cfg_dec_en_i | input | 1 | Window decode enable |
| io_addr_i | input | 16 | I/O byte address |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| io_wdata_i | input | 16 | Write data |
| io_rdata_o | output | 32 | Read data, combinational, zero when no read hits |
| io_hit_o | output | 1 | Access hits the window |
| tmr_tick_i | input | 1 | Timer advance enable |
| pwrbtn_evt_i | input | 1 | Power button event pulse |
| rtc_evt_i | input | 1 | RTC event pulse |
| gbl_evt_i | input | 1 | Global lock event pulse |
| ctl_o | output | 16 | Control register value |
| sci_o | output | 1 | System control interrupt level |

## Verification
The hardest situation to reach from the ports is a timer overflow. At full width the top bit first changes only after 2^23 ticks. The bench therefore builds the block with a 10-bit timer and holds the tick input high, so the rising change comes after 512 ticks and the wrap to zero after 1024. This exercises both directions of R9.

The second hard case is a set/clear collision. The bench places an event pulse in the same cycle as a clearing write to that bit.

// File: rtl/pm_evt_pkg.sv
`timescale 1ns/1ps
package pm_evt_pkg;
  localparam int REG_W = 16;
  localparam int OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_STS = 4'h0;
  localparam logic [OFS_W-1:0] OFS_EN  = 4'h2;
  localparam logic [OFS_W-1:0] OFS_CTL = 4'h4;
  localparam logic [OFS_W-1:0] OFS_TMR = 4'h8;

  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;

  localparam logic [REG_W-1:0] EVT_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_EN,
    SEL_CTL,
    SEL_TMR
  } reg_sel_e;

  typedef struct packed {
    logic     wr;
    logic     rd;
    reg_sel_e sel;
  } acc_t;
endpackage

// File: rtl/pm_evt_decode.sv
`timescale 1ns/1ps
module pm_evt_decode
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              dec_en_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              wide_i,
  output acc_t              acc_o,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] WIN_MASK = {ADDR_W{1'b1}} << WIN_BITS;

  logic             in_win;
  logic [OFS_W-1:0] ofs;
  reg_sel_e         sel;

  assign in_win = dec_en_i && ((addr_i & WIN_MASK) == (base_i & WIN_MASK));
  assign ofs    = addr_i[OFS_W-1:0];

  always_comb begin
    sel = SEL_NONE;
    if (in_win) begin
      if (wide_i) begin
        if (ofs == OFS_TMR) sel = SEL_TMR;
      end else begin
        case (ofs)
          OFS_STS: sel = SEL_STS;
          OFS_EN:  sel = SEL_EN;
          OFS_CTL: sel = SEL_CTL;
          default: sel = SEL_NONE;
        endcase
      end
    end
  end

  assign acc_o.wr  = wr_i && in_win;
  assign acc_o.rd  = rd_i && in_win;
  assign acc_o.sel = sel;
  assign hit_o     = in_win && (wr_i || rd_i);
endmodule

// File: rtl/pm_evt_timer.sv
`timescale 1ns/1ps
module pm_evt_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [TMR_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt;
  end

  // top bit change in either direction
  assign ovf_o = tick_i && (cnt_q[TMR_W-1] ^ cnt_nxt[TMR_W-1]);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pm_evt_regs.sv
`timescale 1ns/1ps
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter logic [REG_W-1:0] STS_IMPL = EVT_MASK,
  parameter logic [REG_W-1:0] SCI_SRC  = EVT_MASK
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_t             acc_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] evt_set_i,
  output logic [REG_W-1:0] sts_o,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] ctl_o,
  output logic             sci_o
);
  logic             wr_sts, wr_en, wr_ctl;
  logic [REG_W-1:0] sts_q, en_q, ctl_q;

  assign wr_sts = acc_i.wr && (acc_i.sel == SEL_STS);
  assign wr_en  = acc_i.wr && (acc_i.sel == SEL_EN);
  assign wr_ctl = acc_i.wr && (acc_i.sel == SEL_CTL);

  for (genvar g = 0; g < REG_W; g++) begin : g_sts
    if (STS_IMPL[g]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     sts_q[g] <= 1'b0;
        else if (evt_set_i[g])           sts_q[g] <= 1'b1;  // set beats clear
        else if (wr_sts && wdata_i[g])   sts_q[g] <= 1'b0;
      end
    end else begin : g_tie
      assign sts_q[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_en)  en_q  <= wdata_i;
      if (wr_ctl) ctl_q <= wdata_i;
    end
  end

  assign sci_o = |(sts_q & en_q & SCI_SRC);
  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign ctl_o = ctl_q;
endmodule

// File: rtl/pm_evt_block.sv
`timescale 1ns/1ps
module pm_evt_block
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 6,
  parameter int TMR_W    = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic              cfg_dec_en_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic              io_wide_i,
  input  logic [REG_W-1:0]  io_wdata_i,
  output logic [31:0]       io_rdata_o,
  output logic              io_hit_o,
  input  logic              tmr_tick_i,
  input  logic              pwrbtn_evt_i,
  input  logic              rtc_evt_i,
  input  logic              gbl_evt_i,
  output logic [REG_W-1:0]  ctl_o,
  output logic              sci_o
);
  acc_t             acc;
  logic [TMR_W-1:0] tmr_q;
  logic             tmr_ovf;
  logic [REG_W-1:0] evt_set;
  logic [REG_W-1:0] sts_q, en_q, ctl_q;

  pm_evt_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_decode (
    .addr_i   (io_addr_i),
    .base_i   (cfg_base_i),
    .dec_en_i (cfg_dec_en_i),
    .wr_i     (io_wr_i),
    .rd_i     (io_rd_i),
    .wide_i   (io_wide_i),
    .acc_o    (acc),
    .hit_o    (io_hit_o)
  );

  pm_evt_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tmr_tick_i),
    .cnt_o  (tmr_q),
    .ovf_o  (tmr_ovf)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[BIT_TMR] = tmr_ovf;
    evt_set[BIT_GBL] = gbl_evt_i;
    evt_set[BIT_PWR] = pwrbtn_evt_i;
    evt_set[BIT_RTC] = rtc_evt_i;
  end

  pm_evt_regs #(.STS_IMPL(EVT_MASK), .SCI_SRC(EVT_MASK)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .wdata_i   (io_wdata_i),
    .evt_set_i (evt_set),
    .sts_o     (sts_q),
    .en_o      (en_q),
    .ctl_o     (ctl_q),
    .sci_o     (sci_o)
  );

  always_comb begin
    io_rdata_o = '0;
    if (acc.rd) begin
      case (acc.sel)
        SEL_STS: io_rdata_o = 32'(sts_q);
        SEL_EN:  io_rdata_o = 32'(en_q);
        SEL_CTL: io_rdata_o = 32'(ctl_q);
        SEL_TMR: io_rdata_o = 32'(tmr_q);
        default: io_rdata_o = '0;
      endcase
    end
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/pm_evt_block_chk.sv
`timescale 1ns/1ps
module pm_evt_block_chk
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_dec_en_i,
  input logic             io_wr_i,
  input logic             io_wide_i,
  input logic [31:0]      io_rdata_o,
  input logic             io_hit_o,
  input logic             tmr_tick_i,
  input logic             pwrbtn_evt_i,
  input logic             rtc_evt_i,
  input logic             sci_o,
  input logic [REG_W-1:0] sts,
  input logic [REG_W-1:0] en,
  input logic [TMR_W-1:0] tmr
);
  // R6
  pwr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrbtn_evt_i |=> sts[BIT_PWR]);

  // R6
  rtc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtc_evt_i |=> sts[BIT_RTC]);

  // R10
  wide_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_wide_i) |=> $stable(en));

  // R2
  dec_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_dec_en_i |-> (!io_hit_o && io_rdata_o == 32'h0));

  // R8
  tmr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_tick_i |=> tmr == TMR_W'($past(tmr) + 1'b1));

  // R8
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tmr_tick_i |=> $stable(tmr));

  // R7
  sci_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en & EVT_MASK) == '0) |-> !sci_o);

  // R5
  sts_impl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts & ~EVT_MASK) == '0);
endmodule

bind pm_evt_block pm_evt_block_chk #(.TMR_W(TMR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_dec_en_i (cfg_dec_en_i),
  .io_wr_i      (io_wr_i),
  .io_wide_i    (io_wide_i),
  .io_rdata_o   (io_rdata_o),
  .io_hit_o     (io_hit_o),
  .tmr_tick_i   (tmr_tick_i),
  .pwrbtn_evt_i (pwrbtn_evt_i),
  .rtc_evt_i    (rtc_evt_i),
  .sci_o        (sci_o),
  .sts          (sts_q),
  .en           (en_q),
  .tmr          (tmr_q)
);

// File: tb/pm_evt_block_bench.sv
`timescale 1ns/1ps
module pm_evt_block_bench;
  localparam int TW = 10;
  localparam logic [31:0] TMASK = (32'h1 << TW) - 1;
  localparam logic [31:0] EVM = 32'h0521;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_base = 16'h4025;
  logic        cfg_en = 1'b1;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0, wide = 1'b0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        hit;
  logic        tick = 1'b0, pwr = 1'b0, rtc = 1'b0, gbl = 1'b0;
  logic [15:0] ctl;
  logic        sci;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pm_evt_block #(.TMR_W(TW)) u_pm_evt_block (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base_i(cfg_base), .cfg_dec_en_i(cfg_en),
    .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd), .io_wide_i(wide),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .io_hit_o(hit),
    .tmr_tick_i(tick), .pwrbtn_evt_i(pwr), .rtc_evt_i(rtc), .gbl_evt_i(gbl),
    .ctl_o(ctl), .sci_o(sci)
  );

  // behavioural reference state
  logic [31:0] m_sts = 0, m_en = 0, m_ctl = 0, m_tmr = 0;

  function automatic bit m_hit(logic [15:0] a);
    return cfg_en && ((a & 16'hFFC0) == (cfg_base & 16'hFFC0));
  endfunction

  function automatic logic [31:0] m_read(logic [15:0] a, bit w);
    if (!m_hit(a)) return 0;
    if (w) return (a[3:0] == 4'h8) ? m_tmr : 0;
    case (a[3:0])
      4'h0: return m_sts;
      4'h2: return m_en;
      4'h4: return m_ctl;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] clr, set, n_en, n_ctl, nt;
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_ctl = 0; m_tmr = 0;
    end else begin
      clr = 0; set = 0; n_en = m_en; n_ctl = m_ctl;
      if (wr && !wide && m_hit(addr)) begin
        if (addr[3:0] == 4'h0) clr = {16'h0, wdata};
        else if (addr[3:0] == 4'h2) n_en = {16'h0, wdata};
        else if (addr[3:0] == 4'h4) n_ctl = {16'h0, wdata};
      end
      if (pwr) set |= 32'h100;
      if (rtc) set |= 32'h400;
      if (gbl) set |= 32'h020;
      if (tick) begin
        nt = (m_tmr + 1) & TMASK;
        if (((nt ^ m_tmr) >> (TW - 1)) & 1) set |= 32'h1;
        m_tmr = nt;
      end
      m_sts = ((m_sts & ~clr) | set) & EVM;
      m_en = n_en;
      m_ctl = n_ctl;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison of the interrupt and control outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 sci", {31'h0, sci}, {31'h0, ((m_sts & m_en & EVM) != 0)});
      chk("R4 ctl_o", {16'h0, ctl}, m_ctl);
    end
  end

  // one access cycle; ev = {rtc, pwr, gbl}
  task automatic acc(bit w, bit r, bit wd, logic [15:0] a, logic [15:0] d,
                     logic [2:0] ev, string req);
    @(negedge clk);
    wr = w; rd = r; wide = wd; addr = a; wdata = d;
    {rtc, pwr, gbl} = ev;
    #1;
    chk({req, " hit"}, {31'h0, hit}, {31'h0, m_hit(a) && (w || r)});
    if (r) chk(req, rdata, m_read(a, wd));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) acc(0, 0, 0, 16'h0, 16'h0, 3'b000, "idle");
  endtask

  task automatic rd16(logic [15:0] a, string req);
    acc(0, 1, 0, a, 16'h0, 3'b000, req);
  endtask

  task automatic wr16(logic [15:0] a, logic [15:0] d, string req);
    acc(1, 0, 0, a, d, 3'b000, req);
  endtask

  localparam logic [15:0] B = 16'h4000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 sci", {31'h0, sci}, 32'h0);
    chk("R1 ctl", {16'h0, ctl}, 32'h0);
    rd16(B + 16'h0, "R1 status");
    rd16(B + 16'h2, "R1 enable");
    rd16(B + 16'h4, "R1 control");
    acc(0, 1, 1, B + 16'h8, 16'h0, 3'b000, "R1 timer");

    // R4 enable and control read/write
    wr16(B + 16'h2, 16'h0523, "R4 wr en");
    rd16(B + 16'h2, "R4 rd en");
    wr16(B + 16'h4, 16'h1234, "R4 wr ctl");
    rd16(B + 16'h4, "R4 rd ctl");
    chk("R4 ctl_o", {16'h0, ctl}, 32'h1234);

    // R6/R7 power button raises SCI, R5 write-1-to-clear
    acc(0, 0, 0, 16'h0, 16'h0, 3'b010, "R6 pwr pulse");
    idle(1);
    chk("R7 sci after pwr", {31'h0, sci}, 32'h1);
    rd16(B, "R6 pwr status");
    wr16(B, 16'h0100, "R5 clear pwr");
    rd16(B, "R5 after clear");
    chk("R7 sci after clear", {31'h0, sci}, 32'h0);

    // R6 collision: RTC pulse with clearing write in same cycle
    acc(0, 0, 0, 16'h0, 16'h0, 3'b100, "R6 rtc pulse");
    acc(1, 0, 0, B, 16'h0400, 3'b100, "R6 rtc collide");
    rd16(B, "R6 set wins");

    // R5 write 0 leaves, write all ones clears, unimplemented bits read 0
    acc(0, 0, 0, 16'h0, 16'h0, 3'b111, "R6 all pulses");
    wr16(B, 16'h0000, "R5 write zero");
    rd16(B, "R5 unchanged");
    wr16(B, 16'hFFFF, "R5 clear all");
    rd16(B, "R5 all clear");

    // R7 enable outside source bits does not raise SCI
    wr16(B + 16'h2, 16'hFADE, "R7 en no gbl");
    acc(0, 0, 0, 16'h0, 16'h0, 3'b001, "R6 gbl pulse");
    idle(1);
    rd16(B, "R5 gbl status");
    chk("R7 sci masked", {31'h0, sci}, 32'h0);
    wr16(B + 16'h2, 16'h0020, "R7 en gbl");
    idle(1);
    chk("R7 sci gbl", {31'h0, sci}, 32'h1);

    // R3 aliasing inside the window
    wr16(B + 16'h12, 16'h0400, "R3 alias en");
    rd16(B + 16'h2, "R3 en via alias");
    rd16(B + 16'h30, "R3 status alias");
    wr16(B + 16'h34, 16'hBEEF, "R3 alias ctl");
    rd16(B + 16'h24, "R3 ctl alias");

    // R2 misses
    wr16(16'h4040, 16'h5555, "R2 wr outside");
    rd16(B + 16'h2, "R2 en unchanged");
    rd16(16'h4042, "R2 rd outside");
    cfg_en = 1'b0;
    wr16(B + 16'h2, 16'h7777, "R2 wr disabled");
    rd16(B + 16'h2, "R2 rd disabled");
    cfg_en = 1'b1;
    rd16(B + 16'h2, "R2 en kept");

    // R10 width rules
    acc(1, 0, 1, B + 16'h2, 16'h1111, 3'b000, "R10 wide wr");
    rd16(B + 16'h2, "R10 en kept");
    rd16(B + 16'h8, "R10 narrow tmr");
    acc(0, 1, 1, B + 16'h0, 16'h0, 3'b000, "R10 wide sts");
    rd16(B + 16'h6, "R10 narrow gap");
    wr16(B + 16'h6, 16'h9999, "R10 wr gap");
    rd16(B + 16'h4, "R10 ctl kept");

    // R8/R9 timer
    wr16(B, 16'hFFFF, "R5 clear");
    wr16(B + 16'h2, 16'h0001, "R9 en tmr");
    tick = 1'b1;
    idle(5);
    acc(0, 1, 1, B + 16'h8, 16'h0, 3'b000, "R8 tmr run");
    idle(500);
    rd16(B, "R9 before rise");
    idle(20);
    acc(0, 1, 1, B + 16'h8, 16'h0, 3'b000, "R8 tmr past half");
    rd16(B, "R9 rise sets");
    chk("R9 sci tmr", {31'h0, sci}, 32'h1);
    wr16(B, 16'h0001, "R9 clear tmr");
    idle(510);
    acc(0, 1, 1, B + 16'h8, 16'h0, 3'b000, "R8 tmr wrapped");
    rd16(B, "R9 wrap sets");
    tick = 1'b0;
    idle(3);
    acc(0, 1, 1, B + 16'h8, 16'h0, 3'b000, "R8 tmr hold");

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 sci reset", {31'h0, sci}, 32'h0);
    chk("R1 ctl reset", {16'h0, ctl}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd16(B, "R1 sts reset");
    rd16(B + 16'h2, "R1 en reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule